// File: doc/BRIEF.md
# Cache Way Replacement Policy Unit

This block holds the replacement bookkeeping for every set of an N-way set-associative cache and tells the cache which way to evict when a miss has to install a new block. The cache controller reports each reference with a one-cycle strobe. The strobe carries the set, the way that was touched, and a flag that says whether the reference was a hit or the install of a new block. Separately, the controller presents a set index on a lookup port and reads back the victim way for that set in the same cycle.

A parameter selects the policy at build time. FIFO keeps one rotating pointer per set. True LRU keeps a full recency ordering per set. NMRU records only the most recently touched way and picks pseudo-randomly among the others, using a free-running shift-register generator. Tags, data arrays and the hit/miss decision belong to the surrounding cache.

The access strobe is a control input. It has no ready signal and the block never applies back-pressure: every strobe is taken on the edge where it is high. The lookup port is likewise always answered.

Top module: `repl_policy_unit`

## Requirements
- R1: After reset, every set reports victim 0 under FIFO and victim NUM_WAYS-1 under LRU. LRU starts from a recency list in ascending way order, with way 0 at the most-recent end. NMRU records way 0 as most recent in every set, so it never reports 0 until another way is touched.
- R2: Under FIFO the victim is the set's pointer. A strobe with acc_fill=1 (install) advances that set's pointer by one, wrapping from NUM_WAYS-1 to 0.
- R3: Under FIFO a strobe with acc_fill=0 (hit) leaves the pointer and the reported victim unchanged.
- R4: Under LRU any strobe, hit or install, makes the touched way the most recent and shifts the more recent ways down one place. The victim is the least recent way of the set.
- R5: Under NMRU the victim is always a way below NUM_WAYS other than the most recently touched way of the requested set. Every strobe records its way as the most recent.
- R6: Under NMRU with four ways and a fixed most-recent way, each of the three other ways is reported at least once over 64 consecutive cycles, because the random source advances every clock.
- R7: Under NMRU with NUM_WAYS=2 the victim equals the LRU victim for every access sequence.
- R8: victim_way depends combinationally on req_set and the stored state. A strobe changes only the state of acc_set, and the change is visible from the next clock edge. Cycles with acc_valid=0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Reference strobe, one cycle per reference |
| acc_fill | input | 1 | 1 = new block installed, 0 = hit |
| acc_set | input | $clog2(NUM_SETS) | Set of the reference |
| acc_way | input | $clog2(NUM_WAYS) | Way touched by the reference |
| req_set | input | $clog2(NUM_SETS) | Set whose victim is requested |
| victim_way | output | $clog2(NUM_WAYS) | Way to evict in req_set |

## Verification
The victim is due in the same cycle that req_set is presented, and a strobe's effect is due one clock edge later. The bench therefore drives every input on the falling edge and compares victim_way one time unit later. At that moment its model holds the state left by the previous rising edge. The model is then updated right after the rising edge that takes the strobe. Because of this, a lookup of a set that is being updated in the same cycle is expected to return the old victim. NMRU cannot be predicted exactly, so it is checked for exclusion of the most recent way, for coverage of the other ways while idle, and, in a two-way build, for equality with the LRU model.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum int {
    POL_FIFO = 0,
    POL_LRU  = 1,
    POL_NMRU = 2
  } policy_e;

  localparam int RND_W = 16;
endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int          W    = repl_pkg::RND_W,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= SEED;
    else if (sr_q[0]) sr_q <= (sr_q >> 1) ^ TAPS;
    else sr_q <= sr_q >> 1;
  end

  assign rnd = sr_q;
endmodule

// File: rtl/repl_fifo_state.sv
module repl_fifo_state #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SW = $clog2(NUM_SETS),
  localparam int WW = $clog2(NUM_WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_fill,
  input  logic [SW-1:0] acc_set,
  input  logic [WW-1:0] acc_way,
  input  logic [SW-1:0] req_set,
  output logic [WW-1:0] victim_way
);
  localparam logic [WW-1:0] LAST = WW'(NUM_WAYS - 1);

  logic [WW-1:0] ptr_q [NUM_SETS];
  logic          unused_way;

  assign unused_way = ^acc_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= '0;
    end else if (acc_valid && acc_fill) begin
      ptr_q[acc_set] <= (ptr_q[acc_set] == LAST) ? '0 : ptr_q[acc_set] + 1'b1;
    end
  end

  assign victim_way = ptr_q[req_set];

  // R2: an install on the looked-up set moves its victim one step around the ring
  p_fill_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fill && req_set == acc_set) |=>
      ((req_set != $past(req_set)) ||
       (victim_way == (($past(victim_way) == LAST) ? '0 : $past(victim_way) + 1'b1))));

  // R3: a hit on the looked-up set leaves its victim alone
  p_hit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fill && req_set == acc_set) |=>
      (!$stable(req_set) || $stable(victim_way)));
endmodule

// File: rtl/repl_lru_state.sv
module repl_lru_state #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SW = $clog2(NUM_SETS),
  localparam int WW = $clog2(NUM_WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_fill,
  input  logic [SW-1:0] acc_set,
  input  logic [WW-1:0] acc_way,
  input  logic [SW-1:0] req_set,
  output logic [WW-1:0] victim_way
);
  // order_q[s][0] is the most recent way, order_q[s][NUM_WAYS-1] the least recent
  logic [WW-1:0] order_q [NUM_SETS][NUM_WAYS];
  logic [WW-1:0] order_nxt [NUM_WAYS];
  logic [WW-1:0] hit_pos;
  logic          unused_fill;

  assign unused_fill = acc_fill;

  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (order_q[acc_set][i] == acc_way) hit_pos = WW'(i);
    end
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (i == 0) order_nxt[i] = acc_way;
      else if (i <= int'(hit_pos)) order_nxt[i] = order_q[acc_set][i-1];
      else order_nxt[i] = order_q[acc_set][i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int i = 0; i < NUM_WAYS; i++) order_q[s][i] <= WW'(i);
    end else if (acc_valid) begin
      for (int i = 0; i < NUM_WAYS; i++) order_q[acc_set][i] <= order_nxt[i];
    end
  end

  assign victim_way = order_q[req_set][NUM_WAYS-1];

  // R4: the way just touched cannot be the least recent of its set
  p_touched_not_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && req_set == acc_set) |=>
      ((req_set != $past(req_set)) || (victim_way != $past(acc_way))));

  // R8: no strobe, no change for a steady lookup
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid) |=> (!$stable(req_set) || $stable(victim_way)));
endmodule

// File: rtl/repl_nmru_state.sv
module repl_nmru_state #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int RW       = repl_pkg::RND_W,
  localparam int SW = $clog2(NUM_SETS),
  localparam int WW = $clog2(NUM_WAYS),
  localparam int OTHERS = NUM_WAYS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_fill,
  input  logic [SW-1:0] acc_set,
  input  logic [WW-1:0] acc_way,
  input  logic [SW-1:0] req_set,
  input  logic [RW-1:0] rnd,
  output logic [WW-1:0] victim_way
);
  logic [WW-1:0] mru_q [NUM_SETS];
  logic [RW-1:0] pick;
  logic [WW-1:0] cand;
  logic [WW-1:0] mru_req;
  logic          unused_fill;

  assign unused_fill = acc_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) mru_q[s] <= '0;
    end else if (acc_valid) begin
      mru_q[acc_set] <= acc_way;
    end
  end

  // map the random value onto 0..OTHERS-1, then skip over the recent way
  assign pick       = rnd % RW'(OTHERS);
  assign cand       = WW'(pick);
  assign mru_req    = mru_q[req_set];
  assign victim_way = (cand >= mru_req) ? cand + 1'b1 : cand;

  // R5: the most recent way is never offered for eviction
  p_never_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_way != mru_req);

  // R5: the victim stays inside the set
  p_victim_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim_way) < NUM_WAYS);

  // R5: a strobe on the looked-up set excludes that way from the next victim
  p_touched_excluded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && req_set == acc_set) |=>
      ((req_set != $past(req_set)) || (victim_way != $past(acc_way))));
endmodule

// File: rtl/repl_policy_unit.sv
module repl_policy_unit #(
  parameter int               NUM_SETS = 16,
  parameter int               NUM_WAYS = 4,
  parameter repl_pkg::policy_e POLICY  = repl_pkg::POL_LRU,
  parameter logic [15:0]      RND_SEED = 16'hACE1,
  localparam int SW = $clog2(NUM_SETS),
  localparam int WW = $clog2(NUM_WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_fill,
  input  logic [SW-1:0] acc_set,
  input  logic [WW-1:0] acc_way,
  input  logic [SW-1:0] req_set,
  output logic [WW-1:0] victim_way
);
  generate
    if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
      repl_fifo_state #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_state (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill),
        .acc_set(acc_set), .acc_way(acc_way), .req_set(req_set),
        .victim_way(victim_way));
    end else if (POLICY == repl_pkg::POL_LRU) begin : g_lru
      repl_lru_state #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_state (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill),
        .acc_set(acc_set), .acc_way(acc_way), .req_set(req_set),
        .victim_way(victim_way));
    end else begin : g_nmru
      logic [repl_pkg::RND_W-1:0] rnd;
      repl_lfsr #(.W(repl_pkg::RND_W), .SEED(RND_SEED)) u_rnd (
        .clk(clk), .rst_n(rst_n), .rnd(rnd));
      repl_nmru_state #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS),
                        .RW(repl_pkg::RND_W)) u_state (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill),
        .acc_set(acc_set), .acc_way(acc_way), .req_set(req_set), .rnd(rnd),
        .victim_way(victim_way));
    end
  endgenerate
endmodule

// File: tb/repl_policy_unit_tb.sv
module repl_policy_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16;
  localparam int NCFG = 4;  // 0: FIFO/4, 1: LRU/4, 2: NMRU/4, 3: NMRU/2

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_fill = 1'b0;
  logic [3:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic [3:0] req_set = '0;
  logic [1:0] victim_bus [NCFG];

  int n_cmp = 0;
  int n_bad = 0;

  int fifo_ptr [SETS];
  int lru4 [SETS][$];
  int lru2 [SETS][$];
  int mru4 [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam int WAYS_G = (g == 3) ? 2 : 4;
    localparam int WW_G = $clog2(WAYS_G);
    localparam repl_pkg::policy_e POL_G = (g == 0) ? repl_pkg::POL_FIFO :
                                          (g == 1) ? repl_pkg::POL_LRU :
                                                     repl_pkg::POL_NMRU;
    logic [WW_G-1:0] vw;
    logic [WW_G-1:0] aw;
    assign aw = acc_way[WW_G-1:0];
    repl_policy_unit #(.NUM_SETS(SETS), .NUM_WAYS(WAYS_G), .POLICY(POL_G)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill),
      .acc_set(acc_set), .acc_way(aw), .req_set(req_set), .victim_way(vw));
    assign victim_bus[g] = 2'(vw);
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s set=%0d actual=%0d expected=%0d", tag, req_set, act, exp);
    end
  endtask

  task automatic check_true(input string tag, input bit ok, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s set=%0d actual=%0d expected=%0d", tag, req_set, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      fifo_ptr[s] = 0;
      mru4[s] = 0;
      lru4[s] = {0, 1, 2, 3};
      lru2[s] = {0, 1};
    end
  endtask

  task automatic lru_touch(ref int q[$], input int w);
    for (int i = 0; i < q.size(); i++) begin
      if (q[i] == w) begin
        q.delete(i);
        break;
      end
    end
    q.push_front(w);
  endtask

  // one clock: drive at the falling edge, compare, then fold the strobe into the model
  task automatic step(input bit v, input bit f, input int s, input int w, input int rs,
                      input string tag);
    @(negedge clk);
    acc_valid = v;
    acc_fill  = f;
    acc_set   = 4'(s);
    acc_way   = 2'(w);
    req_set   = 4'(rs);
    #1;
    check_eq({tag, " fifo R2"}, int'(victim_bus[0]), fifo_ptr[rs]);
    check_eq({tag, " lru R4"}, int'(victim_bus[1]), lru4[rs][3]);
    check_true({tag, " nmru R5"},
               (int'(victim_bus[2]) != mru4[rs]) && (int'(victim_bus[2]) < 4),
               int'(victim_bus[2]), -1);
    check_eq({tag, " nmru2 R7"}, int'(victim_bus[3]), lru2[rs][1]);
    @(posedge clk);
    if (v) begin
      if (f) fifo_ptr[s] = (fifo_ptr[s] + 1) % 4;
      lru_touch(lru4[s], w);
      lru_touch(lru2[s], w % 2);
      mru4[s] = w;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit seen [4];
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every set in its reset state
    for (int s = 0; s < SETS; s++) step(0, 0, 0, 0, s, "R1");
    check_eq("R1 fifo reset", int'(victim_bus[0]), 0);
    check_eq("R1 lru reset", int'(victim_bus[1]), 3);

    // R3: hits do not move the FIFO pointer
    for (int i = 0; i < 4; i++) step(1, 0, 3, i, 3, "R3");
    step(0, 0, 0, 0, 3, "R3");
    check_eq("R3 fifo after hits", int'(victim_bus[0]), 0);

    // R2: installs walk the pointer and wrap
    for (int i = 0; i < 5; i++) step(1, 1, 3, i % 4, 3, "R2 wrap");
    step(0, 0, 0, 0, 3, "R2");
    check_eq("R2 fifo after 5 installs", int'(victim_bus[0]), 1);

    // R4: recency ordering in set 5
    step(1, 0, 5, 0, 5, "R4");
    step(1, 1, 5, 1, 5, "R4");
    step(1, 0, 5, 2, 5, "R4");
    step(1, 0, 5, 3, 5, "R4");
    step(1, 0, 5, 0, 5, "R4");
    step(0, 0, 0, 0, 5, "R4");
    check_eq("R4 lru victim after 0,1,2,3,0", int'(victim_bus[1]), 1);

    // R8: other sets and idle strobes leave set 7 untouched; lookup during update shows old state
    step(1, 1, 8, 2, 7, "R8 other set");
    step(0, 1, 7, 3, 7, "R8 valid low");
    step(1, 1, 7, 3, 7, "R8 same-cycle old");
    step(0, 0, 0, 0, 7, "R8 after edge");
    check_eq("R8 fifo set7 after one install", int'(victim_bus[0]), 1);
    check_eq("R8 fifo set8 untouched by set7", fifo_ptr[8], 1);

    // R6: with way 1 most recent in set 2, the other three ways all come up while idle
    step(1, 0, 2, 1, 2, "R6");
    for (int i = 0; i < 4; i++) seen[i] = 1'b0;
    for (int c = 0; c < 64; c++) begin
      step(0, 0, 0, 0, 2, "R6");
      seen[victim_bus[2]] = 1'b1;
    end
    check_true("R6 way0 seen", seen[0], int'(seen[0]), 1);
    check_true("R6 way2 seen", seen[2], int'(seen[2]), 1);
    check_true("R6 way3 seen", seen[3], int'(seen[3]), 1);
    check_true("R6 mru way1 never", !seen[1], int'(seen[1]), 0);

    // random traffic against the model, all policies at once (R2 R4 R5 R7 R8)
    for (int c = 0; c < 3000; c++) begin
      step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
           $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), "rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule